// File: doc/BRIEF.md
# Phase-Offset Switching Clock Generator

This block produces the switching-cycle start pulse and an in-cycle phase count for a PWM power stage. The cycle reference comes either from an internal divider of the system clock or from the rising edges of an external sync pin. Several converters share one input rail, and each one starts its cycle a selectable fraction of a period after the common reference edge, so their input current pulses interleave.

A three-way mode select, latched when the block is enabled, picks the direction of the sync pin. In drive mode the block runs from its own divider and drives the clock out. In follow mode it measures the incoming period, accepts it only inside a legal window and aligns to each accepted edge. In auto mode it waits a bounded time for a legal clock and otherwise runs from its own divider without driving the pin. A followed clock that stops or leaves the legal range raises a sticky lost flag. The block then keeps switching from its own divider at the last measured period. The phase offset is the low device-address bits in eighth-turn steps, or a sixteenth-turn step count from an override input.

Top module: `phase_clk_gen`

## Requirements
- R1: After reset, cycle_start, sync_oe, sync_out, clk_lost, meas_period and phase_cnt are all zero.
- R2: With mode_sel = 2'b01 at enable (drive mode), sync_oe is 1, cycle_start repeats every INT_PERIOD (40) clocks, and sync_out is high for the first INT_PERIOD/2 clocks of each divider cycle. The sync input has no effect on the cycle, and meas_period stays 0.
- R3: With mode_sel = 2'b00 at enable (follow mode), sync_oe is 0. Once two rising edges of sync_in lie a legal period apart, every accepted rising edge that is first sampled at clock edge N gives a one-clock cycle_start pulse beginning at clock edge N+3+D, where D is the offset delay.
- R4: A sync period P, counted in system clocks between rising edges, is legal only when MIN_PERIOD (16) <= P <= MAX_PERIOD (80). meas_period shows the last legal P. An illegal period gives no cycle_start and no lock.
- R5: Without override, the offset is S = 2*dev_addr[2:0] sixteenth-turn steps, so each address step adds 45 degrees. The upper address bits are ignored. D = floor(S*period/16), where period is INT_PERIOD for the internal divider and meas_period otherwise.
- R6: With ovr_en = 1, S = ovr_steps in 22.5-degree steps. Any value of 16 or more (a full turn) gives D = 0.
- R7: In follow mode after lock, if no accepted edge arrives for floor(1.5*P) clocks, clk_lost rises floor(1.5*P)+1 clocks after the last accepted edge took effect. cycle_start then repeats every P clocks from the internal divider. clk_lost stays set until en drops.
- R8: With mode_sel = 2'b10 or 2'b11 at enable (auto), sync_oe is 0. If a legal clock locks within DET_WIN clocks, the block behaves as in follow mode. Otherwise it runs every INT_PERIOD clocks from its own divider.
- R9: mode_sel is sampled only on the rising edge of en. Changes while enabled have no effect.
- R10: phase_cnt is 0 in the cycle where cycle_start is high and increases by one each clock after that.
- R11: While en is low, there is no cycle_start and sync_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; its rising edge latches the mode |
| sync_in | input | 1 | Sync pin input value |
| mode_sel | input | 2 | 00 follow, 01 drive, 1x auto |
| dev_addr | input | 7 | Device address; low three bits set the offset |
| ovr_en | input | 1 | Use ovr_steps instead of the address |
| ovr_steps | input | 5 | Offset in sixteenth-turn steps |
| sync_out | output | 1 | Sync pin drive value |
| sync_oe | output | 1 | Sync pin drive enable |
| cycle_start | output | 1 | One-clock switching-cycle start pulse |
| phase_cnt | output | 8 | Clocks since the last cycle_start |
| clk_lost | output | 1 | Followed clock lost (sticky) |
| meas_period | output | 8 | Last legal sync period in clocks |

## Verification
The offset is swept over all eight address codes, with the upper address bit set and clear, and over every override step from 0 to 17 plus 31. This pins down the floor arithmetic and the full-turn wrap. Follow mode is tried with periods just inside and just outside both limits, which separates acceptance from rejection. A stopped clock at two different periods shows that the loss time and the fallback frequency both track the measured period and not the internal one. Auto mode is run once with a clock and once without. A mode change and sync toggling applied while the block runs in drive mode show that the latched mode holds and the pin input is ignored.

// File: rtl/phase_clk_pkg.sv
package phase_clk_pkg;

    // sixteenth-turn step count width (0..16 plus headroom)
    localparam int STEP_W    = 5;
    localparam int FULL_TURN = 16;

    localparam logic [1:0] MODE_FOLLOW = 2'b00;
    localparam logic [1:0] MODE_DRIVE  = 2'b01;

    typedef enum logic [2:0] {
        SRC_IDLE,
        SRC_DRIVE,
        SRC_FOLLOW,
        SRC_AUTO_WAIT,
        SRC_QUIET
    } src_e;

    // Offset in sixteenth turns: override steps, or address times two.
    function automatic logic [STEP_W-1:0] step_select(
        input logic              ovr,
        input logic [STEP_W-1:0] ovr_val,
        input logic [2:0]        addr_lo
    );
        if (ovr) begin
            step_select = (ovr_val >= STEP_W'(FULL_TURN)) ? '0 : ovr_val;
        end else begin
            step_select = {1'b0, addr_lo, 1'b0};
        end
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], din};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int CNT_W      = 8,
    parameter int MIN_PERIOD = 16,
    parameter int MAX_PERIOD = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             rise,
    output logic             edge_ok,
    output logic             locked,
    output logic [CNT_W-1:0] meas
);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;

    logic [CNT_W-1:0] gap;
    logic             have_prev;
    logic             gap_legal;

    assign gap_legal = have_prev && (gap >= CNT_W'(MIN_PERIOD)) && (gap <= CNT_W'(MAX_PERIOD));
    assign edge_ok   = run && rise && gap_legal;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            gap       <= '0;
            have_prev <= 1'b0;
            locked    <= 1'b0;
            meas      <= '0;
        end else if (run) begin
            if (rise) begin
                if (gap_legal) begin
                    meas   <= gap;
                    locked <= 1'b1;
                end
                gap       <= CNT_W'(1);
                have_prev <= 1'b1;
            end else if (gap != GAP_MAX) begin
                gap <= gap + CNT_W'(1);
            end
        end
    end

    assert_meas_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        locked |-> (meas >= CNT_W'(MIN_PERIOD) && meas <= CNT_W'(MAX_PERIOD)));

    assert_lock_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(rise));
endmodule

// File: rtl/phase_delay.sv
module phase_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] delay,
    output logic             cycle_start,
    output logic [CNT_W-1:0] phase_cnt
);
    localparam logic [CNT_W-1:0] PC_MAX = '1;

    logic             armed;
    logic [CNT_W-1:0] wait_cnt;
    logic             fire;

    assign fire = armed && (wait_cnt == '0) && !tick;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed       <= 1'b0;
            wait_cnt    <= '0;
            cycle_start <= 1'b0;
            phase_cnt   <= '0;
        end else begin
            cycle_start <= fire;
            if (tick) begin
                armed    <= 1'b1;
                wait_cnt <= delay;
            end else if (fire) begin
                armed <= 1'b0;
            end else if (armed) begin
                wait_cnt <= wait_cnt - CNT_W'(1);
            end
            if (fire)                     phase_cnt <= '0;
            else if (phase_cnt != PC_MAX) phase_cnt <= phase_cnt + CNT_W'(1);
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    assert_phase_zero_R10: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (phase_cnt == '0));
endmodule

// File: rtl/phase_clk_gen.sv
module phase_clk_gen
    import phase_clk_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADDR_W     = 7,
    parameter int INT_PERIOD = 40,
    parameter int MIN_PERIOD = 16,
    parameter int MAX_PERIOD = 80,
    parameter int DET_WIN    = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sync_in,
    input  logic [1:0]        mode_sel,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              ovr_en,
    input  logic [STEP_W-1:0] ovr_steps,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              cycle_start,
    output logic [CNT_W-1:0]  phase_cnt,
    output logic              clk_lost,
    output logic [CNT_W-1:0]  meas_period
);
    localparam int               WIN_W = $clog2(DET_WIN + 1);
    localparam int               PRD_W = STEP_W + CNT_W;
    localparam logic [CNT_W-1:0] D_MAX = '1;

    function automatic logic [CNT_W-1:0] offset_delay(
        input logic [STEP_W-1:0] steps,
        input logic [CNT_W-1:0]  per
    );
        logic [PRD_W-1:0] prod;
        prod = PRD_W'(steps) * PRD_W'(per);
        return prod[CNT_W+3:4];
    endfunction

    src_e              src;
    logic              en_q, en_rise;
    logic [CNT_W-1:0]  d, per_sel, delay;
    logic [CNT_W:0]    lost_lim;
    logic [WIN_W-1:0]  win;
    logic              lost, rise, edge_ok, locked;
    logic              meter_run, free_run, on_int, lost_evt, to_quiet, ref_tick;
    logic [STEP_W-1:0] steps;
    logic              addr_hi_unused;

    assign addr_hi_unused = ^dev_addr[ADDR_W-1:3];
    assign en_rise   = en & ~en_q;
    assign on_int    = (src == SRC_DRIVE) || (src == SRC_QUIET);
    assign meter_run = en && !lost && ((src == SRC_FOLLOW) || (src == SRC_AUTO_WAIT));
    assign free_run  = on_int || lost;
    assign per_sel   = on_int ? CNT_W'(INT_PERIOD) : meas_period;
    assign lost_lim  = {1'b0, meas_period} + {2'b00, meas_period[CNT_W-1:1]};
    assign lost_evt  = (src == SRC_FOLLOW) && locked && !lost && ({1'b0, d} >= lost_lim);
    assign to_quiet  = (src == SRC_AUTO_WAIT) && !edge_ok && (win == WIN_W'(DET_WIN - 1));
    assign ref_tick  = en && !en_rise &&
                       (edge_ok || lost_evt || (free_run && (d == per_sel - CNT_W'(1))));
    assign steps     = step_select(ovr_en, ovr_steps, dev_addr[2:0]);
    assign delay     = offset_delay(steps, per_sel);
    assign sync_oe   = (src == SRC_DRIVE);
    assign sync_out  = sync_oe && (d < CNT_W'(INT_PERIOD / 2));
    assign clk_lost  = lost;

    sync_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .rise (rise)
    );

    period_meter #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD),
        .MAX_PERIOD (MAX_PERIOD)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .run     (meter_run),
        .rise    (rise),
        .edge_ok (edge_ok),
        .locked  (locked),
        .meas    (meas_period)
    );

    phase_delay #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .tick        (ref_tick),
        .delay       (delay),
        .cycle_start (cycle_start),
        .phase_cnt   (phase_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            src  <= SRC_IDLE;
            d    <= '0;
            lost <= 1'b0;
            win  <= '0;
        end else begin
            en_q <= en;
            if (!en) begin
                src  <= SRC_IDLE;
                d    <= '0;
                lost <= 1'b0;
                win  <= '0;
            end else if (en_rise) begin
                d    <= '0;
                lost <= 1'b0;
                win  <= '0;
                case (mode_sel)
                    MODE_DRIVE:  src <= SRC_DRIVE;
                    MODE_FOLLOW: src <= SRC_FOLLOW;
                    default:     src <= SRC_AUTO_WAIT;
                endcase
            end else begin
                if (ref_tick || to_quiet) d <= '0;
                else if (d != D_MAX)      d <= d + CNT_W'(1);
                if (lost_evt) lost <= 1'b1;
                if (src == SRC_AUTO_WAIT) begin
                    if (edge_ok)       src <= SRC_FOLLOW;
                    else if (to_quiet) src <= SRC_QUIET;
                    else               win <= win + WIN_W'(1);
                end
            end
        end
    end

    assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_oe && en) |=> sync_oe);

    assert_off_when_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sync_oe && !cycle_start));

    assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (clk_lost && en) |=> clk_lost);

    assert_drive_never_lost_R2: assert property (@(posedge clk) disable iff (rst)
        sync_oe |-> !clk_lost);
endmodule

// File: tb/tb_phase_clk_gen.sv
module tb_phase_clk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int INT_P      = 40;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       sync_in = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic [6:0] dev_addr = '0;
    logic       ovr_en = 1'b0;
    logic [4:0] ovr_steps = '0;
    logic       sync_out, sync_oe, cycle_start, clk_lost;
    logic [7:0] phase_cnt, meas_period;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int sync_per = 0;
    int scnt = 0;
    int last_rise = 0;
    bit done = 0;

    phase_clk_gen dut (
        .clk(clk), .rst(rst), .en(en), .sync_in(sync_in), .mode_sel(mode_sel),
        .dev_addr(dev_addr), .ovr_en(ovr_en), .ovr_steps(ovr_steps),
        .sync_out(sync_out), .sync_oe(sync_oe), .cycle_start(cycle_start),
        .phase_cnt(phase_cnt), .clk_lost(clk_lost), .meas_period(meas_period)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // external sync source, updated away from the active edge
    always @(negedge clk) begin
        if (sync_per != 0) begin
            scnt = (scnt + 1 == sync_per) ? 0 : scnt + 1;
            sync_in = (scnt < sync_per / 2);
            if (scnt == 0) last_rise = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_sync(input int p);
        sync_in = 1'b0;
        scnt = p / 2;
        sync_per = p;
    endtask

    task automatic stop_sync();
        sync_per = 0;
        sync_in = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enable_with(input logic [1:0] m, input logic [6:0] a,
                               input logic oe, input logic [4:0] s);
        @(negedge clk);
        en = 1'b0;
        wait_cycles(3);
        mode_sel = m; dev_addr = a; ovr_en = oe; ovr_steps = s;
        en = 1'b1;
    endtask

    task automatic wait_cs(output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cycle_start) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic wait_sync_rise(output int t);
        logic prev;
        t = -1;
        prev = sync_out;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sync_out && !prev) begin
                t = cyc;
                break;
            end
            prev = sync_out;
        end
    endtask

    task automatic count_cs(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cycle_start) c++;
        end
    endtask

    // internal-divider offset check: cycle_start D+1 clocks after sync_out rises
    task automatic drive_case(input logic [6:0] a, input logic oe, input logic [4:0] s,
                              input int exp_d, input string req);
        int t0, t1, t2;
        enable_with(2'b01, a, oe, s);
        wait_cycles(5);
        wait_sync_rise(t0);
        wait_cs(t1);
        check(t1 - t0 == exp_d + 1, req, t1 - t0, exp_d + 1);
        wait_cs(t2);
        check(t2 - t1 == INT_P, "R2", t2 - t1, INT_P);
    endtask

    initial begin
        int t0, t1, t2, c, d_exp, lp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cycle_start == 0 && sync_oe == 0 && sync_out == 0 && clk_lost == 0
              && meas_period == 0 && phase_cnt == 0, "R1", int'(sync_oe), 0);

        // R2 drive mode basics
        enable_with(2'b01, 7'h00, 1'b0, 5'd0);
        wait_cycles(5);
        check(sync_oe == 1, "R2", int'(sync_oe), 1);
        wait_sync_rise(t0);
        c = 0;
        for (int i = 0; i < INT_P; i++) begin
            if (sync_out) c++;
            @(negedge clk);
        end
        check(c == INT_P / 2, "R2", c, INT_P / 2);
        // R10 phase count
        wait_cs(t1);
        wait_cycles(5);
        check(phase_cnt == 5, "R10", phase_cnt, 5);

        // R5 address offset sweep, upper address bit ignored
        for (int a = 0; a < 8; a++) begin
            drive_case(7'(a), 1'b0, 5'd0, (2 * a * INT_P) / 16, "R5");
            drive_case(7'(a) | 7'h20, 1'b0, 5'd0, (2 * a * INT_P) / 16, "R5");
        end

        // R6 override sweep including wrap and clamp
        for (int s = 0; s < 18; s++) begin
            d_exp = (s >= 16) ? 0 : (s * INT_P) / 16;
            drive_case(7'h03, 1'b1, 5'(s), d_exp, "R6");
        end
        drive_case(7'h05, 1'b1, 5'd31, 0, "R6");

        // R9 mode change while enabled; R2 sync input ignored
        enable_with(2'b01, 7'h00, 1'b0, 5'd0);
        wait_cycles(10);
        mode_sel = 2'b00;
        start_sync(30);
        wait_cs(t1);
        wait_cs(t2);
        check(sync_oe == 1, "R9", int'(sync_oe), 1);
        check(t2 - t1 == INT_P, "R2", t2 - t1, INT_P);
        check(meas_period == 0, "R2", meas_period, 0);
        stop_sync();

        // R11 disabled
        @(negedge clk);
        en = 1'b0;
        wait_cycles(2);
        count_cs(100, c);
        check(c == 0 && sync_oe == 0, "R11", c, 0);

        // R3 follow mode latency with address offsets, period 50
        for (int a = 0; a < 8; a++) begin
            start_sync(50);
            enable_with(2'b00, 7'(a), 1'b0, 5'd0);
            wait_cycles(160);
            d_exp = (2 * a * 50) / 16;
            wait_cs(t1);
            check(t1 - last_rise == 4 + d_exp, "R3", t1 - last_rise, 4 + d_exp);
            check(meas_period == 50 && sync_oe == 0, "R3", meas_period, 50);
            stop_sync();
        end

        // R4 legal range boundaries
        for (int k = 0; k < 4; k++) begin
            lp = (k == 0) ? 15 : (k == 1) ? 16 : (k == 2) ? 80 : 81;
            start_sync(lp);
            enable_with(2'b00, 7'h00, 1'b0, 5'd0);
            count_cs(400, c);
            if (lp == 15 || lp == 81) begin
                check(c == 0, "R4", c, 0);
                check(meas_period == 0, "R4", meas_period, 0);
            end else begin
                check(c > 0, "R4", c, 1);
                check(meas_period == 8'(lp), "R4", meas_period, lp);
            end
            stop_sync();
        end

        // R7 loss detection and fallback at measured period
        for (int k = 0; k < 2; k++) begin
            lp = (k == 0) ? 50 : 64;
            start_sync(lp);
            enable_with(2'b00, 7'h00, 1'b0, 5'd0);
            wait_cycles(4 * lp);
            check(clk_lost == 0, "R7", int'(clk_lost), 0);
            stop_sync();
            t0 = -1;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (clk_lost) begin
                    t0 = cyc;
                    break;
                end
            end
            check(t0 - last_rise == 4 + lp + lp / 2, "R7", t0 - last_rise, 4 + lp + lp / 2);
            wait_cs(t1);
            wait_cs(t2);
            check(t2 - t1 == lp, "R7", t2 - t1, lp);
            check(clk_lost == 1, "R7", int'(clk_lost), 1);
        end

        // R8 auto mode with a clock
        start_sync(50);
        enable_with(2'b10, 7'h00, 1'b0, 5'd0);
        wait_cycles(200);
        wait_cs(t1);
        check(t1 - last_rise == 4, "R8", t1 - last_rise, 4);
        check(meas_period == 50 && sync_oe == 0, "R8", meas_period, 50);
        stop_sync();

        // R8 auto mode without a clock
        enable_with(2'b11, 7'h00, 1'b0, 5'd0);
        wait_cycles(300);
        wait_cs(t1);
        wait_cs(t2);
        check(t2 - t1 == INT_P, "R8", t2 - t1, INT_P);
        check(sync_oe == 0, "R8", int'(sync_oe), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule